// File: doc/BRIEF.md
# Output Bus Test Pattern Generator

This block sits in front of a converter's digital output bus. In normal operation it forwards each sample word to the output. On request, it replaces the sample stream with programmed test words, so that the receiving logic can be checked in the system without a known analog input. A small byte-wide configuration port writes a control byte and two 16-bit test words. The control byte holds an output-test-mode field and a user-mode field.

In static user mode, one word is held on the bus. In alternate user mode, the two words take turns on successive sample clocks, and the first word always comes first. The configuration port runs on its own clock. The enable and mode flags reach the sample domain through a synchronizer, so the pattern appears a few sample clocks after the write. The test words are latched into the sample domain only when the synchronized enable first takes effect.

Top module: `out_test_pattern`

## Requirements
- R1: While reset is held, `data_o` is zero. While no test pattern is active, `data_o` equals the `smp_data_i` value sampled on the previous `smp_clk_i` rising edge.
- R2: A write to address 0 sets the control byte: bits [3:0] are the output-test-mode field and bits [7:6] are the user-mode field. A test-mode value of 0 keeps the sample data flowing through whatever the user mode is. Any nonzero value turns the pattern on.
- R3: User mode 00 (static): every output word while active is word 1.
- R4: User mode 01 (alternate): the output alternates word 1, word 2, word 1, ... on consecutive sample clocks, starting with word 1 on the first pattern cycle after each activation.
- R5: User modes 10 and 11 are reserved and behave exactly like static mode.
- R6: After the configuration edge that turns the pattern on, the first pattern word appears on `data_o` no earlier than the 3rd and no later than the 5th following `smp_clk_i` rising edge.
- R7: Word 1 is {address 2, address 1} and word 2 is {address 4, address 3}, with the high byte first. The output carries the low `DATA_W` bits of the word, and the higher bits are dropped.
- R8: The test words are captured when the pattern is turned on. Word writes made while the pattern is active leave the output unchanged until the pattern is turned off and on again.
- R9: After the configuration edge that writes a test-mode value of 0, `data_o` returns to sample data no earlier than the 3rd and no later than the 5th following `smp_clk_i` rising edge.
- R10: Writes to addresses 5 to 7 change no stored word or control setting.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk_i | input | 1 | Configuration clock |
| smp_clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| smp_data_i | input | DATA_W | Converter sample word |
| data_o | output | DATA_W | Output bus word |

## Verification
A wrong activity flag shows within one sample clock: sample data leaks into the pattern, or a test word replaces live data. A wrong phase bit or a late start shows on the first two pattern words as word 2 leading, or as the same word repeating in alternate mode. Corrupt captured words, or words that track a later register write, show as a wrong value on the first pattern cycle or on any cycle after the write. A broken synchronizer chain shows as a start or stop latency outside the three-to-five-cycle window.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;
  localparam int CFG_AW = 3;
  localparam int CFG_DW = 8;
  localparam int WORD_W = 16;
  localparam int N_WORD = 2;

  localparam logic [CFG_AW-1:0] ADDR_CTRL      = 3'd0;
  localparam logic [CFG_AW-1:0] ADDR_WORD_BASE = 3'd1;

  typedef enum logic [1:0] {
    UM_STATIC    = 2'b00,
    UM_ALTERNATE = 2'b01,
    UM_RSV_A     = 2'b10,
    UM_RSV_B     = 2'b11
  } user_mode_e;
endpackage

// File: rtl/otp_sync.sv
`timescale 1ns/1ps
module otp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/otp_cfg_regs.sv
`timescale 1ns/1ps
module otp_cfg_regs
  import otp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic              en_o,
  output logic              alt_o,
  output logic [WORD_W-1:0] w1_o,
  output logic [WORD_W-1:0] w2_o
);
  localparam int BPW    = WORD_W / CFG_DW;
  localparam int N_BYTE = N_WORD * BPW;

  logic [N_BYTE-1:0][CFG_DW-1:0] byte_q;
  logic                          en_q;
  logic                          alt_q;

  // Decoded flags are stored as single flops so each crosses glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      alt_q <= 1'b0;
    end else if (we_i && addr_i == ADDR_CTRL) begin
      en_q  <= |wdata_i[3:0];
      alt_q <= (user_mode_e'(wdata_i[7:6]) == UM_ALTERNATE);
    end
  end

  for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
    localparam logic [CFG_AW-1:0] BADDR = CFG_AW'(int'(ADDR_WORD_BASE) + b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         byte_q[b] <= '0;
      else if (we_i && addr_i == BADDR)    byte_q[b] <= wdata_i;
    end
  end

  assign en_o  = en_q;
  assign alt_o = alt_q;
  assign w1_o  = byte_q[BPW-1:0];
  assign w2_o  = byte_q[2*BPW-1:BPW];
endmodule

// File: rtl/otp_pattern_mux.sv
`timescale 1ns/1ps
module otp_pattern_mux #(
  parameter int DATA_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_s_i,
  input  logic              alt_s_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic [WORD_W-1:0] w2_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic [DATA_W-1:0] data_o
);
  logic              act_q;
  logic              phase_q;
  logic [WORD_W-1:0] w1_cap_q;
  logic [WORD_W-1:0] w2_cap_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] pat_word;

  // Words are quasi-static here: sampled once the synchronized enable is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      phase_q  <= 1'b0;
      w1_cap_q <= '0;
      w2_cap_q <= '0;
    end else if (en_s_i && !act_q) begin
      act_q    <= 1'b1;
      phase_q  <= 1'b0;
      w1_cap_q <= w1_i;
      w2_cap_q <= w2_i;
    end else if (!en_s_i) begin
      act_q    <= 1'b0;
    end else begin
      phase_q  <= ~phase_q;
    end
  end

  assign pat_word = (alt_s_i && phase_q) ? w2_cap_q[DATA_W-1:0] : w1_cap_q[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= act_q ? pat_word : smp_data_i;
  end

  if (DATA_W < WORD_W) begin : g_trunc
    logic unused_hi;
    assign unused_hi = ^{w1_cap_q[WORD_W-1:DATA_W], w2_cap_q[WORD_W-1:DATA_W]};
  end

  assign data_o = data_q;
endmodule

// File: rtl/out_test_pattern.sv
`timescale 1ns/1ps
module out_test_pattern
  import otp_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cfg_clk_i,
  input  logic              smp_clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic [DATA_W-1:0] data_o
);
  logic              en_c, alt_c;
  logic [1:0]        flags_s;
  logic [WORD_W-1:0] w1_c, w2_c;

  otp_cfg_regs u_regs (
    .clk_i   (cfg_clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .en_o    (en_c),
    .alt_o   (alt_c),
    .w1_o    (w1_c),
    .w2_o    (w2_c)
  );

  otp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (smp_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({alt_c, en_c}),
    .q_o    (flags_s)
  );

  otp_pattern_mux #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_mux (
    .clk_i      (smp_clk_i),
    .rst_ni     (rst_ni),
    .en_s_i     (flags_s[0]),
    .alt_s_i    (flags_s[1]),
    .w1_i       (w1_c),
    .w2_i       (w2_c),
    .smp_data_i (smp_data_i),
    .data_o     (data_o)
  );
endmodule

// File: rtl/otp_pattern_chk.sv
`timescale 1ns/1ps
module otp_pattern_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_s_i,
  input logic              alt_s_i,
  input logic              act_q,
  input logic              phase_q,
  input logic [DATA_W-1:0] w1_c,
  input logic [DATA_W-1:0] w2_c,
  input logic [DATA_W-1:0] smp_data_i,
  input logic [DATA_W-1:0] data_o
);
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |=> data_o == $past(smp_data_i)); // R1
  AST_WORD1_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && !(alt_s_i && phase_q) |=> data_o == $past(w1_c)); // R3
  AST_WORD2_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && alt_s_i && phase_q |=> data_o == $past(w2_c)); // R4
  AST_PHASE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> !phase_q); // R4
  AST_PHASE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && $past(act_q) |-> phase_q != $past(phase_q)); // R4
  AST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s_i && !act_q |=> act_q); // R6
  AST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s_i |=> !act_q); // R9
  AST_WORDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && $past(act_q) |-> $stable(w1_c) && $stable(w2_c)); // R8
endmodule

bind otp_pattern_mux otp_pattern_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_s_i     (en_s_i),
  .alt_s_i    (alt_s_i),
  .act_q      (act_q),
  .phase_q    (phase_q),
  .w1_c       (w1_cap_q[DATA_W-1:0]),
  .w2_c       (w2_cap_q[DATA_W-1:0]),
  .smp_data_i (smp_data_i),
  .data_o     (data_o)
);

// File: tb/out_test_pattern_test.sv
`timescale 1ns/1ps
module out_test_pattern_test;
  localparam int DW = 12;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  um;
    logic [3:0]  otm;
    logic [15:0] w1;
    logic [15:0] w2;
    logic [11:0] e0;
    logic [11:0] e1;
  } vec_t;

  // R3 static, R4 alternate, R5 reserved, R2 nonzero modes, R7 truncation
  localparam vec_t VECS [5] = '{
    '{4'd3, 2'b00, 4'h1, 16'h0123, 16'h0456, 12'h123, 12'h123},
    '{4'd4, 2'b01, 4'h1, 16'h0321, 16'h0654, 12'h321, 12'h654},
    '{4'd5, 2'b10, 4'h8, 16'h0135, 16'h0246, 12'h135, 12'h135},
    '{4'd5, 2'b11, 4'hF, 16'h0357, 16'h0468, 12'h357, 12'h357},
    '{4'd7, 2'b01, 4'h2, 16'hF1A5, 16'hE2B6, 12'h1A5, 12'h2B6}
  };

  logic          cfg_clk = 1'b0, smp_clk = 1'b0, rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [DW-1:0] smp_data = 12'h800;
  logic [DW-1:0] data_o;
  logic [DW-1:0] sent;
  int total = 0, bad = 0;
  int lat;
  bit finished = 0;

  out_test_pattern #(.DATA_W(DW)) uut (
    .cfg_clk_i(cfg_clk), .smp_clk_i(smp_clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .smp_data_i(smp_data), .data_o(data_o)
  );

  always #10 smp_clk = ~smp_clk;
  initial begin #7; forever #15 cfg_clk = ~cfg_clk; end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge smp_clk);
    #5;
    sent     = smp_data;
    smp_data = smp_data + 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge cfg_clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge cfg_clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic wait_pattern();
    int n = 0;
    lat = 0;
    while (lat == 0 && n < 8) begin
      step(); n++;
      if (data_o != sent) lat = n;
    end
  endtask

  task automatic wait_pass();
    int n = 0;
    lat = 0;
    while (lat == 0 && n < 8) begin
      step(); n++;
      if (data_o == sent) lat = n;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    string rq;
    #15;
    chk(data_o == '0, "R1 reset", 16'(data_o), 16'h0);
    repeat (3) @(negedge smp_clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(data_o == sent, "R1 pass-through", 16'(data_o), 16'(sent));
    end

    // R2: alternate user mode with test mode 0 stays pass-through
    wr(3'd1, 8'h77); wr(3'd0, 8'h40);
    for (int i = 0; i < 8; i++) begin
      step();
      chk(data_o == sent, "R2 mode zero", 16'(data_o), 16'(sent));
    end

    foreach (VECS[k]) begin
      rq = $sformatf("R%0d", VECS[k].req);
      wr(3'd1, VECS[k].w1[7:0]);  wr(3'd2, VECS[k].w1[15:8]);
      wr(3'd3, VECS[k].w2[7:0]);  wr(3'd4, VECS[k].w2[15:8]);
      wr(3'd0, {VECS[k].um, 2'b00, VECS[k].otm});
      wait_pattern();
      chk(lat >= 3 && lat <= 5, "R6 start latency", 16'(lat), 16'd4);
      chk(data_o == VECS[k].e0, {rq, " first word"}, 16'(data_o), 16'(VECS[k].e0));
      step();
      chk(data_o == VECS[k].e1, {rq, " second word"}, 16'(data_o), 16'(VECS[k].e1));
      step();
      chk(data_o == VECS[k].e0, {rq, " third word"}, 16'(data_o), 16'(VECS[k].e0));
      wr(3'd0, {VECS[k].um, 2'b00, 4'h0});
      wait_pass();
      chk(lat >= 3 && lat <= 5, "R9 stop latency", 16'(lat), 16'd4);
      step();
      chk(data_o == sent, "R1 pass after stop", 16'(data_o), 16'(sent));
    end

    // R8: word writes while active are not seen until re-enable
    wr(3'd1, 8'h11); wr(3'd2, 8'h01);
    wr(3'd0, 8'h01);
    wait_pattern();
    chk(data_o == 12'h111, "R8 initial word", 16'(data_o), 16'h111);
    wr(3'd1, 8'h22);
    repeat (6) step();
    chk(data_o == 12'h111, "R8 held while active", 16'(data_o), 16'h111);
    wr(3'd0, 8'h00);
    wait_pass();

    // R10: unmapped addresses change nothing
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(data_o == sent, "R10 no enable from unmapped", 16'(data_o), 16'(sent));
    end
    wr(3'd0, 8'h01);
    wait_pattern();
    chk(data_o == 12'h122, "R8 new word after re-enable", 16'(data_o), 16'h122);
    step();
    chk(data_o == 12'h122, "R10 word unchanged", 16'(data_o), 16'h122);

    // R4: alternate restarts with word 1 after re-entry
    wr(3'd0, 8'h00);
    wait_pass();
    wr(3'd3, 8'h44); wr(3'd4, 8'h03);
    wr(3'd0, 8'h41);
    wait_pattern();
    chk(data_o == 12'h122, "R4 restart word 1", 16'(data_o), 16'h122);
    step();
    chk(data_o == 12'h344, "R4 restart word 2", 16'(data_o), 16'h344);
    finish_run();
  end
endmodule